// File: doc/BRIEF.md
# Boost PWM Timing Generator

This block sets the gate-drive timing of a current-mode boost converter. It runs on the nominal 8 MHz system clock, which gives 125 ns per cycle. A 5-bit frequency code sets the switching period by dividing that clock. Instead of the internal divider, an external synchronisation input can supply the start of each switching cycle. Each switching cycle begins with the gate driven on. The gate turns off when the digitised current comparator trips, but never before a code-selected minimum on time has elapsed. After turning off, the gate stays off for at least a code-selected minimum off time before a new cycle may begin.

An overvoltage input overrides all other behaviour and forces the gate off. Status outputs mark the first cycle of each pulse, the blanking window in which a comparator trip cannot yet end the pulse, and pulses that ended at the maximum-duty limit rather than on a comparator trip.

Top module: `bst_pwm_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `gate`, `cyc_start`, `blank` and `max_hit` are all low.
- R2: When `freq_code` is 0, no gate pulse is produced, in internal mode and in external-sync mode.
- R3: In internal mode with `freq_code` = c, where c is not 0, successive `cyc_start` pulses are c+7 clock cycles apart. Code 1 gives 8 cycles and code 31 gives 38 cycles.
- R4: The minimum on time for `ton_code` 0, 1, 2 and 3 is 2, 2, 3 and 3 cycles. A comparator trip seen inside this window is remembered, and the gate turns off exactly when the window ends.
- R5: A comparator trip sampled in the k-th high cycle, where k is at least the minimum on time, gives a pulse exactly k cycles long.
- R6: If the comparator never trips, the pulse lasts P−M cycles, where P is the period in cycles and M is the minimum off time in cycles. `max_hit` is high for one cycle, in the first low cycle after such a pulse.
- R7: The minimum off time for `toff_code` 0, 1, 2 and 3 is 1, 1, 2 and 2 cycles. If a start request arrives before the gate has been low that long, the start is deferred until the minimum off time has been met.
- R8: When `ext_sel` is 1, the internal divider does not start cycles. A rising edge on `ext_sync` starts a cycle, and the gate rises on the third clock edge after the input rises.
- R9: While `ovp` is high, `gate` is low in that same cycle. No pulse starts until `ovp` clears, and normal pulsing then resumes.
- R10: `cyc_start` is high only in the first high cycle of each pulse. `blank` is high in the first N−1 high cycles of each pulse, where N is the minimum on time in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| freq_code | input | 5 | Period code; 0 disables switching |
| ton_code | input | 2 | Minimum on-time selector |
| toff_code | input | 2 | Minimum off-time selector |
| ext_sel | input | 1 | 1: cycles start on external sync edges |
| ext_sync | input | 1 | External switching clock, asynchronous |
| cmp_trip | input | 1 | Peak-current comparator output |
| ovp | input | 1 | Overvoltage shutdown request |
| gate | output | 1 | Gate-on request to the pre-driver |
| cyc_start | output | 1 | First high cycle of a pulse |
| blank | output | 1 | Comparator blanking window active |
| max_hit | output | 1 | Previous pulse ended at the duty limit |

## Verification
A wrong on-cycle count shows at the port as a pulse of the wrong width within one switching period. This is clearest when the comparator is held high, because the pulse width is then exactly the minimum on time. A missing trip latch shows as a pulse that runs on to the duty limit, together with a `max_hit` pulse. A wrong off-cycle count or a lost deferred start shows as a low gap between two sync-driven pulses that is one cycle off, which is visible within five cycles of the second sync edge. Errors in the period counter or the sync path shift the spacing of `cyc_start` pulses, or the delay from a sync edge to the gate rise, in the first cycle that is measured.

// File: rtl/bst_pwm_pkg.sv
package bst_pwm_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } gate_st_e;

    typedef struct packed {
        logic cyc_start;
        logic max_hit;
    } pwm_flags_t;

    // Switching period in system clocks; code 0 means switching is disabled.
    function automatic int period_cyc(int code, int base);
        return (code == 0) ? 0 : code + base;
    endfunction

    function automatic int min_on_ns(int code);
        case (code)
            0:       return 150;
            1:       return 200;
            2:       return 260;
            default: return 300;
        endcase
    endfunction

    function automatic int min_off_ns(int code);
        case (code)
            0:       return 115;
            1:       return 75;
            2:       return 195;
            default: return 155;
        endcase
    endfunction

    // Round a duration up to whole clock periods.
    function automatic int ns_to_cycles(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/bst_sync_edge.sv
module bst_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh_q[g] <= 1'b0;
                else     sh_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh_q[g] <= 1'b0;
                else     sh_q[g] <= sh_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sh_q[STAGES-1];
    end

    assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/bst_period_cnt.sv
module bst_period_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q >= period - CNT_W'(1));
    assign wrap = en & last;

    always_ff @(posedge clk) begin
        if (rst || !en) cnt_q <= '0;
        else if (last)  cnt_q <= '0;
        else            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/bst_gate_fsm.sv
module bst_gate_fsm
    import bst_pwm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             ovp,
    input  logic             start_req,
    input  logic             cmp_trip,
    input  logic [CNT_W-1:0] ton_cyc,
    input  logic [CNT_W-1:0] toff_cyc,
    input  logic [CNT_W-1:0] on_lim,
    output logic             gate,
    output logic             blank,
    output pwm_flags_t       flags
);
    gate_st_e         st_q;
    logic [CNT_W-1:0] on_cnt;   // high cycles so far, this cycle included
    logic [CNT_W-1:0] off_cnt;  // low cycles so far, this cycle included, saturating
    logic [CNT_W-1:0] off_inc;
    logic             end_q;    // trip or sync seen during blanking
    logic             pend_q;   // start request waiting for min off time
    pwm_flags_t       flags_q;
    logic             end_now, at_lim, go_now;

    assign off_inc = (off_cnt == '1) ? off_cnt : off_cnt + CNT_W'(1);
    assign end_now = (cmp_trip | end_q | start_req) && (on_cnt >= ton_cyc);
    assign at_lim  = (on_cnt >= on_lim);
    assign go_now  = (start_req | pend_q) && (off_cnt >= toff_cyc);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            on_cnt  <= '0;
            off_cnt <= '1;
            end_q   <= 1'b0;
            pend_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            flags_q <= '0;
            if (ovp || !enable) begin
                st_q    <= ST_OFF;
                on_cnt  <= '0;
                end_q   <= 1'b0;
                pend_q  <= 1'b0;
                off_cnt <= (st_q == ST_ON) ? CNT_W'(1) : off_inc;
            end else if (st_q == ST_ON) begin
                pend_q <= pend_q | start_req;
                if (end_now) begin
                    st_q    <= ST_OFF;
                    off_cnt <= CNT_W'(1);
                end else if (at_lim) begin
                    st_q            <= ST_OFF;
                    off_cnt         <= CNT_W'(1);
                    flags_q.max_hit <= 1'b1;
                end else begin
                    on_cnt <= on_cnt + CNT_W'(1);
                    end_q  <= end_q | cmp_trip | start_req;
                end
            end else begin
                if (go_now) begin
                    st_q              <= ST_ON;
                    on_cnt            <= CNT_W'(1);
                    end_q             <= 1'b0;
                    pend_q            <= 1'b0;
                    flags_q.cyc_start <= 1'b1;
                end else begin
                    pend_q  <= pend_q | start_req;
                    off_cnt <= off_inc;
                end
            end
        end
    end

    assign gate  = (st_q == ST_ON) & ~ovp;
    assign blank = gate & (on_cnt < ton_cyc);
    assign flags = flags_q;
endmodule

// File: rtl/bst_pwm_gen.sv
module bst_pwm_gen
    import bst_pwm_pkg::*;
#(
    parameter int FREQ_W      = 5,
    parameter int CODE_W      = 2,
    parameter int CLK_NS      = 125,
    parameter int DIV_BASE    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] freq_code,
    input  logic [CODE_W-1:0] ton_code,
    input  logic [CODE_W-1:0] toff_code,
    input  logic              ext_sel,
    input  logic              ext_sync,
    input  logic              cmp_trip,
    input  logic              ovp,
    output logic              gate,
    output logic              cyc_start,
    output logic              blank,
    output logic              max_hit
);
    localparam int MAX_PER = (1 << FREQ_W) - 1 + DIV_BASE;
    localparam int CNT_W   = $clog2(MAX_PER + 1);

    logic [CNT_W-1:0] per_w, ton_w, toff_w, lim_w;
    logic             enable, wrap, sync_rise, start_req;
    pwm_flags_t       flags;

    always_comb begin
        per_w  = CNT_W'(period_cyc(int'(freq_code), DIV_BASE));
        ton_w  = CNT_W'(ns_to_cycles(min_on_ns(int'(ton_code)), CLK_NS));
        toff_w = CNT_W'(ns_to_cycles(min_off_ns(int'(toff_code)), CLK_NS));
        lim_w  = per_w - toff_w;
    end

    assign enable    = (freq_code != '0);
    assign start_req = ext_sel ? sync_rise : wrap;

    bst_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_sync),
        .rise (sync_rise)
    );

    bst_period_cnt #(.CNT_W(CNT_W)) u_per (
        .clk    (clk),
        .rst    (rst),
        .en     (enable & ~ext_sel),
        .period (per_w),
        .wrap   (wrap)
    );

    bst_gate_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .ovp       (ovp),
        .start_req (start_req),
        .cmp_trip  (cmp_trip),
        .ton_cyc   (ton_w),
        .toff_cyc  (toff_w),
        .on_lim    (lim_w),
        .gate      (gate),
        .blank     (blank),
        .flags     (flags)
    );

    assign cyc_start = flags.cyc_start;
    assign max_hit   = flags.max_hit;
endmodule

// File: rtl/bst_pwm_chk.sv
module bst_pwm_chk
    import bst_pwm_pkg::*;
#(
    parameter int FREQ_W = 5,
    parameter int CODE_W = 2,
    parameter int CLK_NS = 125
) (
    input logic              clk,
    input logic              rst,
    input logic [FREQ_W-1:0] freq_code,
    input logic [CODE_W-1:0] ton_code,
    input logic [CODE_W-1:0] toff_code,
    input logic              ovp,
    input logic              gate,
    input logic              cyc_start
);
    logic [7:0] run_q, low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            low_q <= '1;
        end else begin
            run_q <= gate ? run_q + 8'd1 : 8'd0;
            low_q <= gate ? 8'd0 : ((low_q == '1) ? low_q : low_q + 8'd1);
        end
    end

    // R9
    assert_ovp_off_R9: assert property (@(posedge clk) disable iff (rst)
        $past(ovp) |-> !gate);

    // R2
    assert_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(freq_code) == '0) |-> !gate);

    // R4
    assert_min_on_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(gate) && !gate && !ovp && !$past(ovp) && $past(freq_code) != '0)
        |-> (int'(run_q) >= ns_to_cycles(min_on_ns(int'($past(ton_code))), CLK_NS)));

    // R7
    assert_min_off_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> (int'(low_q) >= ns_to_cycles(min_off_ns(int'($past(toff_code))), CLK_NS)));

    // R10
    assert_start_marks_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> cyc_start);

    assert_start_with_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !ovp) |-> gate);
endmodule

bind bst_pwm_gen bst_pwm_chk #(
    .FREQ_W (FREQ_W),
    .CODE_W (CODE_W),
    .CLK_NS (CLK_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .freq_code (freq_code),
    .ton_code  (ton_code),
    .toff_code (toff_code),
    .ovp       (ovp),
    .gate      (gate),
    .cyc_start (cyc_start)
);

// File: tb/bst_pwm_gen_test.sv
module bst_pwm_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] freq = '0;
    logic [1:0] tonc = '0;
    logic [1:0] toffc = '0;
    logic       ext_sel = 1'b0, ext_sync = 1'b0, cmp = 1'b0, ovp = 1'b0;
    logic       cmp_base = 1'b0;
    logic       gate, cyc_start, blank, max_hit;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    bst_pwm_gen uut (
        .clk (clk), .rst (rst), .freq_code (freq), .ton_code (tonc),
        .toff_code (toffc), .ext_sel (ext_sel), .ext_sync (ext_sync),
        .cmp_trip (cmp), .ovp (ovp), .gate (gate), .cyc_start (cyc_start),
        .blank (blank), .max_hit (max_hit)
    );

    function automatic int n_on(int c);  return (c < 2) ? 2 : 3; endfunction
    function automatic int m_off(int c); return (c < 2) ? 1 : 2; endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; freq = '0; tonc = '0; toffc = '0; ext_sel = 1'b0;
        ext_sync = 1'b0; cmp = 1'b0; cmp_base = 1'b0; ovp = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_start(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cyc_start) begin ok = 1'b1; break; end
        end
    endtask

    // Measures one pulse and the period to the next start. trip_at > 0 pulses
    // the comparator in that high cycle.
    task automatic pulse_meas(input int trip_at, output int hi, output int blanks,
                              output bit maxseen, output int per);
        bit ok, lowseen;
        wait_start(ok);
        hi = ok ? 1 : 0; blanks = (ok && blank) ? 1 : 0; per = 0;
        maxseen = 1'b0; lowseen = 1'b0;
        if (ok && trip_at == 1) cmp = 1'b1;
        for (int i = 0; i < 200 && ok; i++) begin
            @(negedge clk);
            cmp = cmp_base;
            per++;
            if (!lowseen && gate) begin
                hi++;
                if (blank) blanks++;
                if (hi == trip_at) cmp = 1'b1;
            end else lowseen = 1'b1;
            if (max_hit) maxseen = 1'b1;
            if (cyc_start) break;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 outputs in reset", {gate, cyc_start, blank, max_hit}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after release", {gate, cyc_start, blank, max_hit}, 0);
    endtask

    task automatic t_disable();
        int highs = 0;
        do_reset();
        for (int i = 0; i < 80; i++) begin @(negedge clk); if (gate) highs++; end
        chk("R2 code 0 internal", highs, 0);
        ext_sel = 1'b1; highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            ext_sync = (i % 8) < 4;
            if (gate) highs++;
        end
        chk("R2 code 0 ext sync", highs, 0);
    endtask

    task automatic t_period(input int code, input int toff);
        int hi, bl, per; bit mx;
        do_reset();
        freq = 5'(code); toffc = 2'(toff);
        pulse_meas(0, hi, bl, mx, per);
        chk("R3 period", per, code + 7);
        chk("R6 untripped width", hi, code + 7 - m_off(toff));
        chk("R6 max_hit flagged", int'(mx), 1);
    endtask

    task automatic t_min_on(input int ton);
        int hi, bl, per; bit mx;
        do_reset();
        freq = 5'd31; tonc = 2'(ton); cmp_base = 1'b1; cmp = 1'b1;
        pulse_meas(0, hi, bl, mx, per);
        chk("R4 width with comparator held", hi, n_on(ton));
        chk("R10 blank cycles", bl, n_on(ton) - 1);
        chk("R6 no max_hit on trip", int'(mx), 0);
    endtask

    task automatic t_latch();
        int hi, bl, per; bit mx;
        do_reset();
        freq = 5'd31; tonc = 2'd3;
        pulse_meas(1, hi, bl, mx, per);
        chk("R4 trip in blanking remembered", hi, 3);
    endtask

    task automatic t_late_trip(input int k);
        int hi, bl, per; bit mx;
        do_reset();
        freq = 5'd20; tonc = 2'd0;
        pulse_meas(k, hi, bl, mx, per);
        chk("R5 width equals trip cycle", hi, k);
        chk("R3 period unchanged by trip", per, 27);
    endtask

    task automatic t_ext_start();
        int highs = 0, cnt = 0;
        do_reset();
        freq = 5'd31; ext_sel = 1'b1; cmp_base = 1'b1; cmp = 1'b1;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (gate) highs++; end
        chk("R8 no divider starts in ext mode", highs, 0);
        ext_sync = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ext_sync = 1'b0;
            cnt++;
            if (gate) break;
        end
        chk("R8 sync to gate edges", cnt, 3);
        chk("R10 start flag on sync pulse", int'(cyc_start), 1);
    endtask

    task automatic t_ext_min_off(input int toff);
        int hi = 0, lo = 0, phase = 0;
        do_reset();
        freq = 5'd31; ext_sel = 1'b1; toffc = 2'(toff); cmp_base = 1'b1; cmp = 1'b1;
        @(negedge clk);
        ext_sync = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ext_sync = 1'b0;
            if (gate) break;
        end
        ext_sync = 1'b1;
        hi = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ext_sync = 1'b0;
            if (phase == 0) begin
                if (gate) hi++;
                else begin phase = 1; lo = 1; end
            end else if (!gate) lo++;
            else break;
        end
        chk("R4 ext pulse width", hi, 2);
        chk("R7 deferred start gap", lo, m_off(toff));
    endtask

    task automatic t_ovp();
        bit ok; int highs = 0; int found = 0;
        do_reset();
        freq = 5'd31;
        wait_start(ok);
        ovp = 1'b1;
        #1;
        chk("R9 gate drops in same cycle", int'(gate), 0);
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (gate) highs++; end
        chk("R9 held off", highs, 0);
        ovp = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (gate) begin found = 1; break; end
        end
        chk("R9 resumes after clear", found, 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_disable();
        t_period(1, 0);
        t_period(31, 0);
        t_period(31, 2);
        t_period(9, 3);
        for (int t = 0; t < 4; t++) t_min_on(t);
        t_latch();
        t_late_trip(10);
        t_ext_start();
        t_ext_min_off(2);
        t_ext_min_off(0);
        t_ovp();
        finish_run();
    end
endmodule